// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets a bus master read and write a bank of byte-wide registers. SCL and SDA are oversampled by the system clock through two-flop synchronizers. The system clock must run at least ten times faster than SCL. Edge detection on the synchronized lines yields START, repeated START, STOP and the SCL rising and falling events that drive a single state machine. SDA is driven open-drain: the block raises `sda_pull` when it wants the line low and otherwise leaves it released.

A transfer begins with the 7-bit device address. Its upper six bits are fixed by a parameter (default 001100b) and its lowest bit equals the `addr_strap` pin. The address is followed by the R/W bit. In write direction, the first byte after the address is a sub-address. Its low seven bits load the register pointer and its top bit switches on pointer auto-increment. Every following byte is written to the register the pointer selects. A read is a write of the sub-address, then a repeated START and the address with R/W=1. The block then returns bytes MSB first until the master answers a byte with a not-acknowledge. The pointer keeps its value across STOP and START.

The state machine has these states:
- IDLE: waits for START.
- DEV_ADDR: shifts in the address byte.
- DEV_ACK: acknowledges a matching address.
- SUB_ADDR and SUB_ACK: take and acknowledge the sub-address.
- WR_DATA and WR_ACK: take, store and acknowledge write bytes.
- RD_DATA: shifts a read byte out.
- RD_ACK: samples the master's answer.
- IGNORE: sits out the rest of a transfer that is not for this block.

Its transitions are:
- START from any state goes to DEV_ADDR.
- STOP from any state goes to IDLE.
- DEV_ADDR goes to DEV_ACK on an address match and to IGNORE on a mismatch.
- DEV_ACK goes to SUB_ADDR for a write and to RD_DATA for a read.
- SUB_ACK goes to WR_DATA.
- WR_DATA goes to WR_ACK, and WR_ACK returns to WR_DATA.
- RD_DATA goes to RD_ACK.
- RD_ACK returns to RD_DATA on an acknowledge and goes to IGNORE on a not-acknowledge.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_pull`, `reg_we` and `reg_re` are all low.
- R2: The block acknowledges an address byte exactly when its upper seven bits equal {001100b, `addr_strap`}. With the strap low the write/read bytes are 30h/31h, and with the strap high they are 32h/33h. Bit 0 of the byte is R/W, with 1 meaning read.
- R3: After an address byte that does not match, the block drives no acknowledge. It leaves SDA released and makes no register access until the next START.
- R4: The sub-address byte loads bits 6..0 into the register pointer. Bit 7 enables auto-increment of the pointer after each data byte.
- R5: Every written data byte is acknowledged. Each one produces exactly one `reg_we` pulse, carrying `reg_addr` equal to the pointer and `reg_wdata` equal to the byte received MSB first. The block never pulls SDA in the cycle of that pulse.
- R6: With auto-increment on, the pointer advances by one after each data byte and wraps from 7Fh to 00h. With auto-increment off, every data byte of the transfer uses the same register.
- R7: In read direction, each byte is fetched with one `reg_re` pulse on the SCL falling edge that opens the byte. The fetched value is shifted out MSB first, and the first bit appears on SDA in the cycle after the pulse.
- R8: A not-acknowledge from the master ends the read. SDA stays released and no `reg_re` occurs until the next START.
- R9: `sda_pull` changes only while SCL is low.
- R10: A STOP returns the block to idle. The register pointer survives STOP and START, so a read without a new sub-address continues from the pointer.
- R11: `reg_we` and `reg_re` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 1 | Device address bit 0 |
| reg_addr | output | 7 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` is sampled in this cycle |

## Verification
The hardest situations to reach are the boundaries between a byte and the acknowledge that follows it. In a long read, the pointer wraps from 7Fh to 00h while the master keeps acknowledging, and the block must fetch the next register at exactly the right SCL fall. The bench reaches this by filling all 128 registers in one auto-increment burst. It then starts bursts just below 7Fh so that the wrap falls mid-transfer. Mismatched addresses are reached by sweeping all 128 address values under both strap levels. After each mismatched address, one more byte is sent to show that it is not acknowledged and produces no register access. A read is also clocked on past the master's not-acknowledge, to show the line stays released.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_SUB_ADDR,
        ST_SUB_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Idle bus level is high, so every stage resets to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            prev  <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic scl_q,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_ev,
    output logic stop_ev
);

    // Data may only move while SCL is low; any SDA edge with SCL high is a framing condition.
    assign start_ev = scl_q & sda_fall;
    assign stop_ev  = scl_q & sda_rise;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
    parameter int         PTR_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              strap,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re
);

    localparam logic [2:0] LAST_BIT = 3'd7;

    slv_state_t        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rx_byte;
    logic [2:0]        bit_cnt;
    logic              half;
    logic              rw;
    logic              inc;
    logic              oe_q;
    logic [PTR_W-1:0]  ptr;
    logic              rx_done;
    logic              addr_hit;

    assign rx_byte  = {shreg[BYTE_W-2:0], sda_s};
    assign rx_done  = scl_rise && (bit_cnt == LAST_BIT);
    assign addr_hit = (rx_byte[7:1] == {DEV_ADDR_HI, strap});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_DEV_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV_ADDR: if (rx_done) nxt = addr_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  if (scl_fall && half) nxt = rw ? ST_RD_DATA : ST_SUB_ADDR;
                ST_SUB_ADDR: if (rx_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall && half) nxt = ST_WR_DATA;
                ST_WR_DATA:  if (rx_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall && half) nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && bit_cnt == LAST_BIT) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_s) nxt = ST_IGNORE;
                    else if (scl_fall)     nxt = ST_RD_DATA;
                end
                ST_IGNORE:   nxt = ST_IGNORE;
            endcase
        end
    end

    // Shift register, bit counter, pointer and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            half    <= 1'b0;
            rw      <= 1'b0;
            inc     <= 1'b0;
            oe_q    <= 1'b0;
            ptr     <= '0;
        end else if (start_ev) begin
            bit_cnt <= '0;
            half    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (stop_ev) begin
            half    <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV_ADDR, ST_SUB_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 3'd1;
                        half    <= 1'b0;
                        if (rx_done && state == ST_DEV_ADDR) rw <= rx_byte[0];
                        if (rx_done && state == ST_SUB_ADDR) begin
                            ptr <= rx_byte[PTR_W-1:0];
                            inc <= rx_byte[7];
                        end
                    end
                end
                ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        if (!half) begin
                            oe_q <= 1'b1;
                            half <= 1'b1;
                        end else begin
                            half    <= 1'b0;
                            bit_cnt <= '0;
                            oe_q    <= 1'b0;
                            if (state == ST_WR_ACK) ptr <= ptr + PTR_W'(inc);
                            if (state == ST_DEV_ACK && rw) begin
                                shreg <= reg_rdata;
                                oe_q  <= ~reg_rdata[7];
                            end
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            oe_q    <= 1'b0;
                            bit_cnt <= '0;
                            ptr     <= ptr + PTR_W'(inc);
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            oe_q    <= ~shreg[BYTE_W-2];
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        shreg   <= reg_rdata;
                        oe_q    <= ~reg_rdata[7];
                        bit_cnt <= '0;
                    end
                end
                ST_IDLE, ST_IGNORE: oe_q <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_pull  = oe_q;
        reg_addr  = ptr;
        reg_wdata = shreg;
        reg_we    = scl_fall && (state == ST_WR_ACK) && !half;
        reg_re    = scl_fall && ((state == ST_DEV_ACK && half && rw) || state == ST_RD_ACK);
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
    parameter int         PTR_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic              addr_strap,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              reg_re
);

    logic scl_q, scl_rise, scl_fall;
    logic sda_q, sda_rise, sda_fall;
    logic start_ev, stop_ev;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (scl_i),
        .q    (scl_q),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_i),
        .q    (sda_q),
        .rise (sda_rise),
        .fall (sda_fall)
    );

    i2c_bus_events u_events (
        .scl_q   (scl_q),
        .sda_rise(sda_rise),
        .sda_fall(sda_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    i2c_slave_fsm #(
        .DEV_ADDR_HI(DEV_ADDR_HI),
        .PTR_W      (PTR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_q),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .strap    (addr_strap),
        .reg_rdata(reg_rdata),
        .sda_pull (sda_pull),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re)
    );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull,
    input logic       reg_we,
    input logic       reg_re,
    input logic [7:0] reg_rdata
);

    // R9: the drive on SDA moves only while the clock line is low
    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_i);

    // R11: strobes are exclusive
    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R11: write strobe lasts one cycle
    assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R11: read strobe lasts one cycle
    assert_re_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R5: SDA is released while a written byte is being stored
    assert_we_while_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !sda_pull);

    // R7: first bit of the fetched byte reaches SDA one cycle after the fetch
    assert_read_msb_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> (sda_pull == !$past(reg_rdata[7])));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_pull (sda_pull),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_rdata(reg_rdata)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;

    localparam int Q = 4;  // system cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_pull;
    logic       sda_line;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       reg_we;
    logic       reg_re;

    assign sda_line = sda_m & ~sda_pull;

    i2c_reg_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_pull  (sda_pull),
        .addr_strap(strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_re    (reg_re)
    );

    logic [7:0] mem   [128];
    logic [7:0] exp_m [128];
    int checks = 0;
    int bad = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int glitch = 0;
    int strobe_err = 0;
    logic oe_d = 1'b0;
    logic we_d = 1'b0;
    logic re_d = 1'b0;
    bit   done = 1'b0;

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]   = 8'h00;
            exp_m[i] = 8'h00;
        end
    end

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (rst_n) begin
            if (reg_we) we_cnt <= we_cnt + 1;
            if (reg_re) re_cnt <= re_cnt + 1;
            if (sda_pull != oe_d && scl) glitch <= glitch + 1;
            if ((reg_we && reg_re) || (reg_we && we_d) || (reg_re && re_d))
                strobe_err <= strobe_err + 1;
        end
        oe_d <= sda_pull;
        we_d <= reg_we;
        re_d <= reg_re;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b;  wq(Q);
        scl = 1'b1; wq(2 * Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = !sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl = 1'b0;
        end
        wq(Q);
        put_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        bit         ack;
        logic [7:0] rd;
        int         we0, re0;

        wq(5);
        // R1: reset state
        chk(sda_pull == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R1", {sda_pull, reg_we, reg_re}, 0);
        rst_n = 1'b1;
        wq(5);
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);

        // R2/R3: every address under both strap levels
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            wq(4);
            for (int a = 0; a < 128; a++) begin
                bit hit;
                hit = (a[6:0] == {6'b001100, s[0]});
                we0 = we_cnt;
                re0 = re_cnt;
                bus_start();
                put_byte({a[6:0], 1'b0}, ack);
                chk(ack == hit, "R2", ack, hit);
                if (!hit) begin
                    put_byte(8'h5A, ack);
                    chk(!ack && we_cnt == we0 && re_cnt == re0, "R3", {ack, we_cnt[7:0]}, {1'b0, we0[7:0]});
                end
                bus_stop();
            end
        end

        strap = 1'b1;
        wq(4);

        // R4/R5/R6: fill all registers in one auto-increment burst
        we0 = we_cnt;
        bus_start();
        put_byte(8'h32, ack);
        chk(ack, "R2", ack, 1);
        put_byte(8'h80, ack);
        chk(ack, "R4", ack, 1);
        for (int i = 0; i < 128; i++) begin
            put_byte(pat(i), ack);
            chk(ack, "R5", ack, 1);
            exp_m[i] = pat(i);
        end
        bus_stop();
        chk(we_cnt - we0 == 128, "R5", we_cnt - we0, 128);

        // R7/R6: read everything back in one burst
        re0 = re_cnt;
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h80, ack);
        bus_start();
        put_byte(8'h33, ack);
        chk(ack, "R2", ack, 1);
        for (int i = 0; i < 128; i++) begin
            get_byte(i != 127, rd);
            chk(rd == exp_m[i], "R7", rd, exp_m[i]);
        end
        bus_stop();
        chk(re_cnt - re0 == 128, "R7", re_cnt - re0, 128);

        // R6: write burst wrapping past 7Fh
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h80 | 8'h7D, ack);
        for (int i = 0; i < 5; i++) begin
            put_byte(8'hC0 + 8'(i), ack);
            exp_m[(8'h7D + i) & 8'h7F] = 8'hC0 + 8'(i);
        end
        bus_stop();

        // R6: write with auto-increment off hits one register
        we0 = we_cnt;
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h10, ack);
        put_byte(8'hA1, ack);
        put_byte(8'hA2, ack);
        put_byte(8'hA3, ack);
        bus_stop();
        exp_m[16] = 8'hA3;
        chk(we_cnt - we0 == 3, "R6", we_cnt - we0, 3);

        // R6: read across the wrap
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h80 | 8'h7E, ack);
        bus_start();
        put_byte(8'h33, ack);
        for (int i = 0; i < 4; i++) begin
            int ad;
            ad = (126 + i) & 127;
            get_byte(i != 3, rd);
            chk(rd == exp_m[ad], "R6", rd, exp_m[ad]);
        end
        bus_stop();

        // R6: read without auto-increment repeats one register; R8: stays quiet after NACK
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h10, ack);
        bus_start();
        put_byte(8'h33, ack);
        for (int i = 0; i < 3; i++) begin
            get_byte(i != 2, rd);
            chk(rd == 8'hA3 && exp_m[17] == pat(17), "R6", rd, 8'hA3);
        end
        re0 = re_cnt;
        get_byte(1'b0, rd);
        chk(rd == 8'hFF && re_cnt == re0, "R8", {rd, re_cnt[7:0]}, {8'hFF, re0[7:0]});
        bus_stop();

        // R10: pointer survives STOP; read from it without a new sub-address
        bus_start();
        put_byte(8'h32, ack);
        put_byte(8'h80 | 8'h20, ack);
        bus_stop();
        bus_start();
        put_byte(8'h33, ack);
        get_byte(1'b1, rd);
        chk(rd == exp_m[32], "R10", rd, exp_m[32]);
        get_byte(1'b0, rd);
        chk(rd == exp_m[33], "R10", rd, exp_m[33]);
        bus_stop();

        // R2: strap low address no longer answers while strap is high
        bus_start();
        put_byte(8'h31, ack);
        chk(!ack, "R2", ack, 0);
        bus_stop();

        // Final register image against the expected model
        for (int i = 0; i < 128; i++)
            chk(mem[i] == exp_m[i], "R5", mem[i], exp_m[i]);

        chk(glitch == 0, "R9", glitch, 0);
        chk(strobe_err == 0, "R11", strobe_err, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule